// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is a serial-bus slave that holds the configuration of a small mixed-signal front end. An external controller drives the four wires of a standard SPI link (select, clock, data in, data out) and reads or writes one 8-bit register per transfer. The register space holds sixteen addresses, and only some of them are backed by storage. The stored values are decoded into plain control outputs for the rest of the chip: converter enables, a master-clock divide select, a loopback switch, a 16-bit inactivity timeout and two detection thresholds.

All four serial wires are oversampled by the system clock through a synchronizer, so the serial clock must be several times slower than `clk`. A transfer is always two bytes, most significant bit first, with select held low for the whole pair. The first byte is a command byte: bit 7 = 1 writes and bit 7 = 0 reads, bits 6:5 are ignored, and bits 4:0 are the address. For a write, the second byte is the data. For a read, the addressed register appears on the data-out wire during the second byte. While reset is low, three register bits copy the levels present on the select, clock and data-in wires, so board straps can choose their power-up values.

Control pins are level signals with no handshake. The serial link itself has no back-pressure: every transfer that completes is accepted.

Top module: `spi_cfg_regs`

## Requirements
- R1: While `rst_n` is low, the backed registers load these defaults: 0x02 = 0xF0, 0x08 = 0x0C, 0x0B through 0x0F = 0x00, 0x04 = 0x08 with its strap bit, and 0x09 = 0x24 with its strap bits. After reset, `miso` is 0.
- R2: A transfer is 16 bits, MSB first, sampled on rising `sck` while `ss_n` is low. In the command byte, bit 7 = 1 selects write and bit 7 = 0 selects read, bits 6:5 have no effect, and bits 4:0 are the address.
- R3: A write updates the addressed register after the 16th rising `sck` edge, without waiting for `ss_n` to rise.
- R4: During a read, `miso` presents the register MSB first over the second byte and changes only after falling `sck` edges. `miso` is 0 during the command byte, during the second byte of a write, and while `ss_n` is high.
- R5: Addresses 0x00, 0x01, 0x03, 0x05, 0x06, 0x07, 0x0A and 0x10 through 0x1F are reserved. They read back 0x00, and writes to them change nothing. In particular, address 0x12 does not alias 0x02.
- R6: If `ss_n` rises before the 16th bit, the transfer is dropped and no register changes.
- R7: Clock edges after the 16th bit, while `ss_n` stays low, are ignored and cannot cause a second write.
- R8: Decoded fields: `dac_en` = reg 0x08 bit 3, `adc_en` = 0x08 bit 2, `mclk_div` = 0x08 bits 1:0, `loopback` = 0x09 bit 6 (1 routes converter output back to converter input), `off_time` = {0x0B, 0x0C}, `adc_ref` = 0x0E, `dac_ref` = 0x0F, `adc_cur` = 0x02, `ain_cfg` = 0x04, `aif_cfg` = 0x09. Register 0x0D is storage only.
- R9: Strap bits, sampled while reset is low: the `sck` level sets 0x04 bit 2, the `mosi` level sets 0x09 bit 0, and the `ss_n` level sets 0x09 bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Synchronous active-low reset, also the strap sampling window |
| ss_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| adc_cur | output | 8 | Converter current setting (reg 0x02) |
| ain_cfg | output | 8 | Analog input setup (reg 0x04) |
| dac_en | output | 1 | Output converter enable |
| adc_en | output | 1 | Input converter enable |
| mclk_div | output | 2 | Master clock divide select |
| aif_cfg | output | 8 | Audio port setup (reg 0x09) |
| loopback | output | 1 | Internal loopback enable |
| off_time | output | 16 | Inactivity timeout in samples |
| adc_ref | output | 8 | Input-side detection threshold |
| dac_ref | output | 8 | Output-side detection threshold |

## Verification
The bench resets twice with opposite strap levels. A design that ties the straps to constants, or mixes up which wire drives which bit, shows a wrong value in one of the two resets. Transfers cut off after 12 and after 15 bits must leave the target untouched; a design that commits on the rise of select, or one bit early, would overwrite it. A 24-bit frame checks that extra clocks neither write twice nor shift the data. Accesses to 0x12 and 0x03 catch an address decode that drops bit 4 or that stores into reserved slots. A command byte with bits 6:5 set catches a decode that uses those bits as part of the address or the mode.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int unsigned NUM_REGS = 16;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 8;

  localparam int unsigned A_ADC_CUR = 2;
  localparam int unsigned A_AIN     = 4;
  localparam int unsigned A_BLK     = 8;
  localparam int unsigned A_AIF     = 9;
  localparam int unsigned A_OFF_HI  = 11;
  localparam int unsigned A_OFF_LO  = 12;
  localparam int unsigned A_SM_CFG  = 13;
  localparam int unsigned A_ADC_REF = 14;
  localparam int unsigned A_DAC_REF = 15;

  // true when the address has storage behind it
  function automatic logic reg_is_impl(input logic [ADDR_W-1:0] a);
    case (a)
      5'(A_ADC_CUR), 5'(A_AIN), 5'(A_BLK), 5'(A_AIF), 5'(A_OFF_HI),
      5'(A_OFF_LO), 5'(A_SM_CFG), 5'(A_ADC_REF), 5'(A_DAC_REF): return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // power-up value, with strap levels folded in
  function automatic logic [DATA_W-1:0] reg_default(input int unsigned a,
      input logic st_ss, input logic st_sck, input logic st_mosi);
    case (a)
      A_ADC_CUR: return 8'hF0;
      A_AIN:     return 8'h08 | {5'd0, st_sck, 2'd0};
      A_BLK:     return 8'h0C;
      A_AIF:     return 8'h24 | {st_ss, 6'd0, st_mosi};
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  // no reset: straps must pass through while reset is held
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk) begin
      chain <= {chain[STAGES-2:0], din[b]};
      prev  <= chain[STAGES-1];
    end
    assign lvl[b]  = chain[STAGES-1];
    assign rise[b] = chain[STAGES-1] & ~prev;
    assign fall[b] = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
  import spi_cfg_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ss_s,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          miso
);
  localparam int unsigned CMD_W   = 8;
  localparam int unsigned FRAME_W = CMD_W + DW;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sh;
  logic [DW-1:0]      rd_sh;

  assign rd_addr = sh[AW-1:0];
  assign miso    = rd_sh[DW-1];

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (!rst_n || ss_s) begin
      cnt   <= '0;
      sh    <= '0;
      rd_sh <= '0;
    end else begin
      if (sck_rise && cnt < CNT_W'(FRAME_W)) begin
        sh  <= {sh[FRAME_W-2:0], mosi_s};
        cnt <= cnt + 1'b1;
        // last bit: sh holds bits 15..1 of the frame
        if (cnt == CNT_W'(FRAME_W - 1) && sh[FRAME_W-2]) begin
          wr_en   <= 1'b1;
          wr_addr <= sh[DW+AW-2:DW-1];
          wr_data <= {sh[DW-2:0], mosi_s};
        end
      end
      if (sck_fall) begin
        if (cnt == CNT_W'(CMD_W))
          rd_sh <= sh[CMD_W-1] ? '0 : rd_data;
        else
          rd_sh <= {rd_sh[DW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
  import spi_cfg_pkg::*;
#(
  parameter int unsigned NR = NUM_REGS,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_ss,
  input  logic                  st_sck,
  input  logic                  st_mosi,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wr_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [DW-1:0]         rd_data,
  output logic [NR-1:0][DW-1:0] regs
);
  localparam int unsigned IDX_W = $clog2(NR);

  for (genvar i = 0; i < NR; i++) begin : g_reg
    if (reg_is_impl(AW'(i))) begin : g_store
      logic [DW-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n)
          r <= reg_default(i, st_ss, st_sck, st_mosi);
        else if (wr_en && wr_addr == AW'(i))
          r <= wr_data;
      end
      assign regs[i] = r;
    end else begin : g_hole
      assign regs[i] = '0;
    end
  end

  assign rd_data = (rd_addr >= AW'(NR)) ? '0 : regs[rd_addr[IDX_W-1:0]];
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ss_n,
  input  logic        sck,
  input  logic        mosi,
  output logic        miso,
  output logic [7:0]  adc_cur,
  output logic [7:0]  ain_cfg,
  output logic        dac_en,
  output logic        adc_en,
  output logic [1:0]  mclk_div,
  output logic [7:0]  aif_cfg,
  output logic        loopback,
  output logic [15:0] off_time,
  output logic [7:0]  adc_ref,
  output logic [7:0]  dac_ref
);
  logic [2:0] lvl, rise, fall;
  logic       ss_s, sck_s, mosi_s, sck_rise, sck_fall;
  logic                           wr_en;
  logic [ADDR_W-1:0]              wr_addr, rd_addr;
  logic [DATA_W-1:0]              wr_data, rd_data;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  spi_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .din({ss_n, sck, mosi}), .lvl(lvl), .rise(rise), .fall(fall));

  assign ss_s     = lvl[2];
  assign sck_s    = lvl[1];
  assign mosi_s   = lvl[0];
  assign sck_rise = rise[1];
  assign sck_fall = fall[1];

  spi_cfg_frame u_frame (
    .clk(clk), .rst_n(rst_n), .ss_s(ss_s), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .rd_data(rd_data),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .miso(miso));

  spi_cfg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .st_ss(ss_s), .st_sck(sck_s),
    .st_mosi(mosi_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .regs(regs));

  assign adc_cur  = regs[A_ADC_CUR];
  assign ain_cfg  = regs[A_AIN];
  assign dac_en   = regs[A_BLK][3];
  assign adc_en   = regs[A_BLK][2];
  assign mclk_div = regs[A_BLK][1:0];
  assign aif_cfg  = regs[A_AIF];
  assign loopback = regs[A_AIF][6];
  assign off_time = {regs[A_OFF_HI], regs[A_OFF_LO]};
  assign adc_ref  = regs[A_ADC_REF];
  assign dac_ref  = regs[A_DAC_REF];
endmodule

// File: rtl/spi_cfg_regs_chk.sv
module spi_cfg_regs_chk
  import spi_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ss_s,
  input logic              sck_fall,
  input logic              miso,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              dac_en,
  input logic              adc_en,
  input logic [1:0]        mclk_div,
  input logic              loopback
);
  // R4
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_s |=> !miso);

  // R4
  miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !ss_s) |=> $stable(miso));

  // R6
  write_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !ss_s);

  // R5
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_is_impl(rd_addr) |-> rd_data == '0);

  // R8
  blk_field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_W'(A_BLK)) |=> $stable({dac_en, adc_en, mclk_div}));

  // R8
  loop_field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_W'(A_AIF)) |=> $stable(loopback));
endmodule

bind spi_cfg_regs spi_cfg_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ss_s(ss_s), .sck_fall(sck_fall), .miso(miso),
  .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_data(rd_data),
  .dac_en(dac_en), .adc_en(adc_en), .mclk_div(mclk_div), .loopback(loopback));

// File: tb/spi_cfg_regs_tb.sv
module spi_cfg_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_n = 1'b0, sck = 1'b1, mosi = 1'b1;
  logic miso, dac_en, adc_en, loopback;
  logic [1:0]  mclk_div;
  logic [7:0]  adc_cur, ain_cfg, aif_cfg, adc_ref, dac_ref;
  logic [15:0] off_time;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  spi_cfg_regs dut_i (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .mosi(mosi),
    .miso(miso), .adc_cur(adc_cur), .ain_cfg(ain_cfg), .dac_en(dac_en),
    .adc_en(adc_en), .mclk_div(mclk_div), .aif_cfg(aif_cfg),
    .loopback(loopback), .off_time(off_time), .adc_ref(adc_ref),
    .dac_ref(dac_ref));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  // driver: shifts one frame, queues the expected read byte of full frames
  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1,
                      input int nbits, input logic [7:0] exp, input string tag);
    logic [23:0] word;
    word = {b0, b1, 8'hFF};
    if (nbits >= 16) begin
      exp_q.push_back(b0[7] ? 8'h00 : exp);
      tag_q.push_back(tag);
    end
    @(negedge clk); ss_n = 1'b0; half();
    for (int i = 0; i < nbits; i++) begin
      mosi = word[23-i]; half();
      sck = 1'b1; half();
      sck = 1'b0;
    end
    half(); ss_n = 1'b1; half(); half();
  endtask

  // monitor: collects MISO at rising SCK, compares full frames
  initial begin
    forever begin
      int n;
      logic [15:0] got;
      @(negedge ss_n);
      n = 0; got = '0;
      forever begin
        @(posedge sck or posedge ss_n);
        if (ss_n) break;
        if (n < 16) got = {got[14:0], miso};
        n++;
      end
      if (n >= 16 && exp_q.size() > 0) begin
        string t;
        logic [7:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, got, {8'h00, e});
      end
    end
  end

  task automatic do_reset(input logic s_ss, input logic s_sck, input logic s_mosi);
    @(negedge clk);
    rst_n = 1'b0; ss_n = s_ss; sck = s_sck; mosi = s_mosi;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); ss_n = 1'b1; @(negedge clk); sck = 1'b0; mosi = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    // R9 straps high on sck/mosi, low on ss
    do_reset(1'b0, 1'b1, 1'b1);
    chk("R1 adc_cur", 16'(adc_cur), 16'hF0);
    chk("R1 blk", {12'd0, dac_en, adc_en, mclk_div}, 16'h000C);
    chk("R1 refs/off", {adc_ref, dac_ref} | off_time, 16'h0000);
    chk("R1 miso", 16'(miso), 16'h0);
    chk("R9 ain strap", 16'(ain_cfg), 16'h0C);
    chk("R9 aif strap", 16'(aif_cfg), 16'h25);
    chk("R8 loopback", 16'(loopback), 16'h0);
    do_reset(1'b1, 1'b0, 1'b0);
    chk("R9 ain strap2", 16'(ain_cfg), 16'h08);
    chk("R9 aif strap2", 16'(aif_cfg), 16'hA4);

    xfer(8'h02, 8'h00, 16, 8'hF0, "R4 read 0x02");
    xfer(8'h08, 8'h00, 16, 8'h0C, "R4 read 0x08");
    xfer(8'h88, 8'h07, 16, 8'h00, "R3 write 0x08");
    chk("R8 blk fields", {12'd0, dac_en, adc_en, mclk_div}, 16'h0007);
    xfer(8'h08, 8'h00, 16, 8'h07, "R3 readback 0x08");
    xfer(8'h89, 8'h40, 16, 8'h00, "R3 write 0x09");
    chk("R8 loopback set", 16'(loopback), 16'h1);
    xfer(8'h8B, 8'h12, 16, 8'h00, "R3 write 0x0B");
    xfer(8'h8C, 8'h34, 16, 8'h00, "R3 write 0x0C");
    xfer(8'h8E, 8'h5A, 16, 8'h00, "R3 write 0x0E");
    xfer(8'h8F, 8'hA5, 16, 8'h00, "R3 write 0x0F");
    chk("R8 off_time", off_time, 16'h1234);
    chk("R8 refs", {adc_ref, dac_ref}, 16'h5AA5);

    // R2 bits 6:5 ignored in both modes
    xfer(8'hED, 8'h77, 16, 8'h00, "R2 write 0x0D");
    xfer(8'h6D, 8'h00, 16, 8'h77, "R2 read 0x0D");

    // R5 reserved holes and no aliasing
    xfer(8'h83, 8'hFF, 16, 8'h00, "R5 write 0x03");
    xfer(8'h03, 8'h00, 16, 8'h00, "R5 read 0x03");
    xfer(8'h92, 8'h11, 16, 8'h00, "R5 write 0x12");
    xfer(8'h02, 8'h00, 16, 8'hF0, "R5 0x02 kept");
    xfer(8'h12, 8'h00, 16, 8'h00, "R5 read 0x12");
    chk("R5 adc_cur", 16'(adc_cur), 16'hF0);

    // R6 aborted frames
    xfer(8'h8E, 8'h00, 12, 8'h00, "R6 abort12");
    chk("R6 adc_ref after 12", 16'(adc_ref), 16'h5A);
    xfer(8'h8E, 8'h00, 15, 8'h00, "R6 abort15");
    chk("R6 adc_ref after 15", 16'(adc_ref), 16'h5A);
    xfer(8'h0E, 8'h00, 16, 8'h5A, "R6 read 0x0E");

    // R7 trailing clocks
    xfer(8'h8F, 8'h3C, 24, 8'h00, "R7 long write");
    chk("R7 dac_ref", 16'(dac_ref), 16'h3C);
    xfer(8'h0F, 8'h00, 24, 8'h3C, "R7 long read");
    chk("R4 miso idle", 16'(miso), 16'h0);

    repeat (20) @(negedge clk);
    if (exp_q.size() != 0) chk("R4 frames seen", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule